// File: doc/BRIEF.md
# Three-Floor Elevator Movement Controller

This block turns floor calls into relative movement commands for a lift car that serves three landings. Each cycle the caller may present a set of floor-call lines together with a strobe. The controller picks one called floor, compares it with the floor the car is at, and raises exactly one of five command lines: descend two, descend one, stay, ascend one or ascend two. The car's floor is held in a register and moves to the chosen floor on the clock edge after the call is accepted.

A build-time option selects the output style. In the combinational-output form the command follows the call in the same cycle and is a function of the stored floor and the live call lines. In the registered-output form the command is held in a state register together with the floor, so it shows up one cycle after the call and depends on state alone. Both forms share the call arbitration, offset decoding and floor register; only the output stage differs.

Top module: `elev3_ctrl`

## Requirements
- R1: Bit k of `req_lines` calls floor k+1 (bit 0 is floor 1, bit 2 is floor 3); a call is accepted only in a cycle where `req_vld` is 1 and at least one call line is 1.
- R2: When several call lines are 1 in an accepted cycle, the lowest-numbered floor is chosen.
- R3: `move_o` is one-hot with bit i meaning an offset of i-2 floors: bit 0 descend two, bit 1 descend one, bit 2 stay, bit 3 ascend one, bit 4 ascend two; the offset is the chosen floor minus the current floor, so calling the current floor gives stay.
- R4: At no time is more than one bit of `move_o` high.
- R5: A cycle with no accepted call yields `move_o` all zeros (in the same cycle for the combinational form, in the next cycle for the registered form).
- R6: With `FORM` set to the combinational form, the command for an accepted call appears in that same cycle.
- R7: With `FORM` set to the registered form, the command for an accepted call appears in the cycle after the call and does not follow the call inputs within a cycle.
- R8: The current floor becomes the chosen floor on the clock edge after an accepted call and is unchanged after a cycle with no accepted call, including back-to-back calls.
- R9: `rst` is synchronous and active high; it puts the car at floor 1, and in the registered form the command after reset is stay (bit 2) until the first cycle after reset is clocked.
- R10: Both forms, built from the same parameter, give the same command sequence for the same call sequence, the registered form delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | Strobe qualifying the call lines this cycle |
| req_lines | input | NUM_FLOORS | One call line per floor, bit 0 for floor 1 |
| move_o | output | 2*NUM_FLOORS-1 | One-hot relative move command, bit NUM_FLOORS-1 is stay |

## Verification
The properties assume that the call inputs are settled at each rising edge and that reset is held for at least one edge before the first call; they do not assume calls are rare or one-hot. The stimulus changes inputs only at falling edges, starts with two reset edges, and deliberately feeds multi-line calls, lines without the strobe and the strobe without lines, so the arbitration and idle properties are reached rather than avoided. A mid-run reset from floor 3 is also applied with the inputs idle, matching the assumption that reset is not combined with a call.

// File: rtl/elev3_pkg.sv
package elev3_pkg;

   // Output style of the controller
   typedef enum logic {
      FORM_MEALY = 1'b0,
      FORM_MOORE = 1'b1
   } form_e;

   // Number of distinct relative commands for a given floor count
   function automatic int unsigned cmd_count(input int unsigned floors);
      return 2 * floors - 1;
   endfunction

endpackage

// File: rtl/elev3_req_arb.sv
module elev3_req_arb #(
   parameter int unsigned NUM_FLOORS = 3,
   parameter int unsigned FLW        = 2
) (
   input  logic                  req_vld,
   input  logic [NUM_FLOORS-1:0] req_lines,
   output logic                  hit,
   output logic [FLW-1:0]        tgt
);

   // Scan from the top floor down so the lowest set line is kept last
   always_comb begin
      hit = req_vld && (|req_lines);
      tgt = '0;
      for (int k = NUM_FLOORS - 1; k >= 0; k--) begin
         if (req_lines[k]) tgt = FLW'(k);
      end
   end

endmodule

// File: rtl/elev3_offset.sv
module elev3_offset #(
   parameter int unsigned NUM_FLOORS = 3,
   parameter int unsigned FLW        = 2,
   parameter int unsigned NI         = 5
) (
   input  logic           en,
   input  logic [FLW-1:0] cur,
   input  logic [FLW-1:0] tgt,
   output logic [NI-1:0]  cmd
);

   localparam int unsigned MAX_OFS = NUM_FLOORS - 1;
   localparam int unsigned IW      = FLW + 1;

   // Biased offset: tgt - cur + MAX_OFS, always in 0 .. 2*MAX_OFS
   logic [IW-1:0] idx;

   always_comb begin
      idx = IW'(tgt) + IW'(MAX_OFS) - IW'(cur);
   end

   for (genvar i = 0; i < NI; i++) begin : g_dec
      assign cmd[i] = en && (idx == IW'(i));
   end

endmodule

// File: rtl/elev3_floor_reg.sv
module elev3_floor_reg #(
   parameter int unsigned FLW = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [FLW-1:0] nxt,
   output logic [FLW-1:0] floor_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         floor_q <= '0;
      end else if (load) begin
         floor_q <= nxt;
      end
   end

endmodule

// File: rtl/elev3_ctrl.sv
module elev3_ctrl #(
   parameter int unsigned       NUM_FLOORS = 3,
   parameter elev3_pkg::form_e  FORM       = elev3_pkg::FORM_MEALY,
   localparam int unsigned      FLW        = $clog2(NUM_FLOORS),
   localparam int unsigned      NI         = elev3_pkg::cmd_count(NUM_FLOORS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  req_vld,
   input  logic [NUM_FLOORS-1:0] req_lines,
   output logic [NI-1:0]         move_o
);

   localparam int unsigned   MAX_OFS  = NUM_FLOORS - 1;
   localparam logic [NI-1:0] STAY_CMD = NI'(1) << MAX_OFS;

   if (NUM_FLOORS < 2) begin : g_bad_floors
      $error("elev3_ctrl: NUM_FLOORS must be at least 2");
   end
   if (NI != 2 * NUM_FLOORS - 1) begin : g_bad_width
      $error("elev3_ctrl: command width does not match floor count");
   end

   logic           call_hit;
   logic [FLW-1:0] call_tgt;
   logic [FLW-1:0] cur_floor;
   logic [NI-1:0]  cmd_comb;

   elev3_req_arb #(
      .NUM_FLOORS (NUM_FLOORS),
      .FLW        (FLW)
   ) u_arb (
      .req_vld   (req_vld),
      .req_lines (req_lines),
      .hit       (call_hit),
      .tgt       (call_tgt)
   );

   elev3_offset #(
      .NUM_FLOORS (NUM_FLOORS),
      .FLW        (FLW),
      .NI         (NI)
   ) u_ofs (
      .en  (call_hit),
      .cur (cur_floor),
      .tgt (call_tgt),
      .cmd (cmd_comb)
   );

   elev3_floor_reg #(
      .FLW (FLW)
   ) u_floor (
      .clk     (clk),
      .rst     (rst),
      .load    (call_hit),
      .nxt     (call_tgt),
      .floor_q (cur_floor)
   );

   if (FORM == elev3_pkg::FORM_MOORE) begin : g_moore
      // State = stored floor plus last issued command
      logic [NI-1:0] cmd_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            cmd_q <= STAY_CMD;
         end else begin
            cmd_q <= cmd_comb;
         end
      end
      assign move_o = cmd_q;
   end else begin : g_mealy
      assign move_o = cmd_comb;
   end

endmodule

// File: rtl/elev3_ctrl_chk.sv
module elev3_ctrl_chk #(
   parameter int unsigned      NUM_FLOORS = 3,
   parameter elev3_pkg::form_e FORM       = elev3_pkg::FORM_MEALY,
   localparam int unsigned     FLW        = $clog2(NUM_FLOORS),
   localparam int unsigned     NI         = elev3_pkg::cmd_count(NUM_FLOORS)
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  req_vld,
   input logic [NUM_FLOORS-1:0] req_lines,
   input logic [NI-1:0]         move_o,
   input logic [FLW-1:0]        cur_floor
);

   function automatic logic [FLW-1:0] lowest(input logic [NUM_FLOORS-1:0] v);
      logic [FLW-1:0] r;
      r = '0;
      for (int k = NUM_FLOORS - 1; k >= 0; k--) begin
         if (v[k]) r = FLW'(k);
      end
      return r;
   endfunction

   logic taken;
   assign taken = req_vld && (req_lines != '0);

   // R4
   move_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(move_o));

   // R1
   floor_range_chk: assert property (@(posedge clk) disable iff (rst)
      cur_floor < FLW'(NUM_FLOORS));

   // R8
   floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !taken |=> $stable(cur_floor));

   // R2
   floor_load_chk: assert property (@(posedge clk) disable iff (rst)
      taken |=> cur_floor == $past(lowest(req_lines)));

   if (FORM == elev3_pkg::FORM_MOORE) begin : g_moore_props
      // R7
      late_cmd_chk: assert property (@(posedge clk) disable iff (rst)
         taken |=> $onehot(move_o));
      // R5
      late_idle_chk: assert property (@(posedge clk) disable iff (rst)
         !taken |=> move_o == '0);
   end else begin : g_mealy_props
      // R6
      same_cmd_chk: assert property (@(posedge clk) disable iff (rst)
         taken |-> $onehot(move_o));
      // R5
      same_idle_chk: assert property (@(posedge clk) disable iff (rst)
         !taken |-> move_o == '0);
   end

endmodule

bind elev3_ctrl elev3_ctrl_chk #(
   .NUM_FLOORS (NUM_FLOORS),
   .FORM       (FORM)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_vld   (req_vld),
   .req_lines (req_lines),
   .move_o    (move_o),
   .cur_floor (cur_floor)
);

// File: tb/elev3_ctrl_tb.sv
module elev3_ctrl_tb;

   localparam int NF = 3;
   localparam int NI = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst = 1'b1;
   logic          vld = 1'b0;
   logic [NF-1:0] lines = '0;
   logic [NI-1:0] mv_me;
   logic [NI-1:0] mv_mo;

   elev3_ctrl #(.NUM_FLOORS(NF), .FORM(elev3_pkg::FORM_MEALY)) u_dut (
      .clk(clk), .rst(rst), .req_vld(vld), .req_lines(lines), .move_o(mv_me));

   elev3_ctrl #(.NUM_FLOORS(NF), .FORM(elev3_pkg::FORM_MOORE)) u_dut_moore (
      .clk(clk), .rst(rst), .req_vld(vld), .req_lines(lines), .move_o(mv_mo));

   int n_cmp = 0;
   int n_bad = 0;

   // Reference state: floor index 0..2 and the registered-form command
   int            ref_floor = 0;
   logic [NI-1:0] ref_late  = 5'b00100;

   // R2: lowest set line, -1 when none
   function automatic int pick(input logic [NF-1:0] l);
      for (int k = 0; k < NF; k++) if (l[k]) return k;
      return -1;
   endfunction

   // R3: bit (tgt - cur + 2)
   function automatic logic [NI-1:0] code(input int cur, input int tgt);
      logic [NI-1:0] v;
      v = '0;
      v[tgt - cur + 2] = 1'b1;
      return v;
   endfunction

   function automatic logic [NI-1:0] now_cmd(input int cur, input logic v,
                                             input logic [NF-1:0] l);
      if (v && pick(l) >= 0) return code(cur, pick(l));
      return '0;
   endfunction

   task automatic chk(input string tag, input string form,
                      input logic [NI-1:0] act, input logic [NI-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, form, act, exp, $time);
      end
   endtask

   task automatic step(input logic r, input logic v, input logic [NF-1:0] l,
                       input string tag);
      @(negedge clk);
      rst = r; vld = v; lines = l;
      #2;
      chk(tag, "comb-form R6", mv_me, now_cmd(ref_floor, v, l));
      chk(tag, "reg-form R7", mv_mo, ref_late);
      // R4: never two commands at once
      n_cmp++;
      if ($countones(mv_me) > 1 || $countones(mv_mo) > 1) begin
         n_bad++;
         $display("FAIL R4: actual %b/%b expected at most one bit", mv_me, mv_mo);
      end
      @(posedge clk);
      if (r) begin
         ref_floor = 0;
         ref_late  = 5'b00100;
      end else if (v && pick(l) >= 0) begin
         ref_late  = code(ref_floor, pick(l));
         ref_floor = pick(l);
      end else begin
         ref_late = '0;
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      int seq[10];
      seq = '{0, 0, 1, 2, 2, 0, 2, 1, 1, 0};
      repeat (2) @(posedge clk);
      // R9: reset state, floor 1 and stay in the registered form
      step(1'b0, 1'b0, 3'b000, "R9");
      // R3/R8: every floor pair, each call followed by an idle cycle (R5)
      foreach (seq[i]) begin
         step(1'b0, 1'b1, 3'(1 << seq[i]), "R3");
         step(1'b0, 1'b0, 3'b000, "R5");
      end
      // R1: lines without strobe, strobe without lines
      step(1'b0, 1'b0, 3'b100, "R1");
      step(1'b0, 1'b1, 3'b000, "R1");
      step(1'b0, 1'b1, 3'b100, "R1");
      // R2: several lines at once
      step(1'b0, 1'b1, 3'b110, "R2");
      step(1'b0, 1'b1, 3'b111, "R2");
      step(1'b0, 1'b1, 3'b101, "R2");
      step(1'b0, 1'b1, 3'b100, "R2");
      // R8: back-to-back calls without idle
      step(1'b0, 1'b1, 3'b001, "R8");
      step(1'b0, 1'b1, 3'b100, "R8");
      step(1'b0, 1'b1, 3'b010, "R8");
      step(1'b0, 1'b1, 3'b100, "R8");
      // R9: reset from floor 3, then a call to floor 3 must be ascend two
      step(1'b1, 1'b0, 3'b000, "R9");
      step(1'b0, 1'b1, 3'b100, "R9");
      step(1'b0, 1'b0, 3'b000, "R9");
      // R10: both forms on a long mixed call stream
      for (int i = 0; i < 300; i++) begin
         logic [31:0] rn;
         rn = $urandom;
         step(1'b0, rn[0] | rn[1], rn[4:2], "R10");
      end
      step(1'b0, 1'b0, 3'b000, "R10");
      summary();
      $finish;
   end

endmodule